// File: doc/BRIEF.md
# DMA channel initialization sequencer

This block is the command front end of a four-channel DMA engine. Software programs a base receive descriptor address and a base transmit descriptor address for every channel. It then marks which directions need a restart, or asks for all of them at once, and sets an action bit in a global command register. The block walks the eight channel directions in a fixed order, one per clock. For each selected direction it copies the base address into that direction's working descriptor pointer and sends a single-cycle start pulse to the channel engine.

Registers are reached through a synchronous write port with a combinational read path. The global command register sits at address 0x00. Bit 0 is the action request, and it reads back as 1 while work is outstanding. Bit 1 asks for every direction to be initialized. Channel c owns addresses 0x20 + 8*c + r, with these values of r:

- r=0: initialize flags. Bit 0 is receive and bit 1 is transmit.
- r=1: receive base address.
- r=2: transmit base address.
- r=3: receive working pointer, read-only.
- r=4: transmit working pointer, read-only.

A request that arrives during a scan is held in a single pending slot and runs straight after the current scan.

Top module: `dma_init_seq`

## Requirements
- R1: After reset all registers and pointers read 0 and no start output is high.
- R2: Only a write of 1 to bit 0 of the global command register starts a scan. Writing the flag registers or writing the global register with bit 0 clear produces no start pulse, and the flags keep their value.
- R3: With global bit 1 set in the request, all eight directions are initialized, whatever the per-channel flags hold.
- R4: With global bit 1 clear, only directions whose flag is set are initialized. Other directions get no pulse and their pointers keep their value.
- R5: Directions are scanned in the order ch0 rx, ch0 tx, ch1 rx, ch1 tx and so on, one per clock. If the request is written at clock edge E0, the direction at scan position k pulses in the cycle after edge E(k+1).
- R6: When a direction pulses, its working pointer reads the base address it held at that edge.
- R7: Global bit 0 reads 1 from the request write until edge E8, and reads 0 after it when nothing is pending.
- R8: A per-channel flag reads 0 after its direction has been served, including when it was served through global bit 1.
- R9: A request written during a scan is not lost. Its scan begins at the edge right after the current scan's last position, so the pulses run on with no gap.
- R10: Setting both flags of every channel with global bit 1 clear gives the same pulses and pointers as global bit 1.
- R11: Every start pulse lasts one cycle, and at most one start output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rx_start | output | 4 | Per-channel receive start pulse |
| tx_start | output | 4 | Per-channel transmit start pulse |

## Verification
A scan index or selection bit that is wrong shows up as a start pulse on the wrong output or in the wrong cycle, within the eight cycles after the request. A busy or pending flag that is wrong shows up at edge E8, as an action bit that clears too early or stays set, or as a gap before the second scan. A faulty load or flag clear is visible when the working pointers and flags are read back right after the scan.

// File: rtl/dma_init_seq.sv
module dma_init_seq #(
  parameter int NCH = 4,
  parameter int PW  = 32,
  parameter int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CHW+3:0]  addr,
  input  logic [PW-1:0]   wdata,
  output logic [PW-1:0]   rdata,
  output logic [NCH-1:0]  rx_start,
  output logic [NCH-1:0]  tx_start
);
  localparam int SW = CHW + 1;
  localparam logic [SW-1:0] LAST = SW'(2*NCH-1);

  logic busy, run_all, pend, pend_all, cmd_all;
  logic [SW-1:0] idx;
  logic [NCH-1:0] rx_init, tx_init;
  logic [NCH-1:0][PW-1:0] rx_base, tx_base, rx_ptr, tx_ptr;

  wire            ch_sel   = addr[CHW+3];
  wire [CHW-1:0]  ch       = addr[CHW+2:3];
  wire [2:0]      reg_sel  = addr[2:0];
  wire            glb_wr   = wr_en && !ch_sel && reg_sel == 3'd0 && ch == '0;
  wire            req      = glb_wr && wdata[0];
  wire [CHW-1:0]  cur_ch   = idx[SW-1:1];
  wire            cur_tx   = idx[0];
  wire            cur_hit  = busy && (run_all || (cur_tx ? tx_init[cur_ch] : rx_init[cur_ch]));
  wire            scan_end = busy && idx == LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      run_all  <= 1'b0;
      pend     <= 1'b0;
      pend_all <= 1'b0;
      cmd_all  <= 1'b0;
      idx      <= '0;
    end else begin
      if (glb_wr) cmd_all <= wdata[1];
      if (busy) begin
        idx <= scan_end ? '0 : idx + 1'b1;
        if (scan_end) begin
          if (pend) begin
            run_all <= pend_all;
            pend    <= 1'b0;
          end else begin
            busy <= 1'b0;
          end
        end
      end
      if (req) begin
        if (!busy || (scan_end && !pend)) begin
          busy    <= 1'b1;
          idx     <= '0;
          run_all <= wdata[1];
        end else begin
          pend     <= 1'b1;
          pend_all <= wdata[1];
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire rx_hit = cur_hit && !cur_tx && cur_ch == CHW'(c);
    wire tx_hit = cur_hit &&  cur_tx && cur_ch == CHW'(c);
    wire ch_wr  = wr_en && ch_sel && ch == CHW'(c);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx_start[c] <= 1'b0;
        tx_start[c] <= 1'b0;
        rx_init[c]  <= 1'b0;
        tx_init[c]  <= 1'b0;
        rx_base[c]  <= '0;
        tx_base[c]  <= '0;
        rx_ptr[c]   <= '0;
        tx_ptr[c]   <= '0;
      end else begin
        rx_start[c] <= rx_hit;
        tx_start[c] <= tx_hit;
        if (rx_hit) begin
          rx_ptr[c]  <= rx_base[c];
          rx_init[c] <= 1'b0;
        end
        if (tx_hit) begin
          tx_ptr[c]  <= tx_base[c];
          tx_init[c] <= 1'b0;
        end
        if (ch_wr && reg_sel == 3'd0) begin
          rx_init[c] <= wdata[0];
          tx_init[c] <= wdata[1];
        end
        if (ch_wr && reg_sel == 3'd1) rx_base[c] <= wdata;
        if (ch_wr && reg_sel == 3'd2) tx_base[c] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!ch_sel) begin
      if (reg_sel == 3'd0 && ch == '0) rdata[1:0] = {cmd_all, busy};
    end else begin
      case (reg_sel)
        3'd0:    rdata[1:0] = {tx_init[ch], rx_init[ch]};
        3'd1:    rdata = rx_base[ch];
        3'd2:    rdata = tx_base[ch];
        3'd3:    rdata = rx_ptr[ch];
        3'd4:    rdata = tx_ptr[ch];
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_init_seq_chk.sv
module dma_init_seq_chk #(
  parameter int NCH = 4,
  parameter int PW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic [NCH-1:0]         rx_start,
  input logic [NCH-1:0]         tx_start,
  input logic [NCH-1:0][PW-1:0] rx_base,
  input logic [NCH-1:0][PW-1:0] tx_base,
  input logic [NCH-1:0][PW-1:0] rx_ptr,
  input logic [NCH-1:0][PW-1:0] tx_ptr
);
  wire [2*NCH-1:0] st = {tx_start, rx_start};

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(st)); // R11
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (|st) |=> ((st & $past(st)) == '0)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> (st == '0)); // R2

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n) rx_start[c] |-> rx_ptr[c] == $past(rx_base[c])); // R6
    AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n) tx_start[c] |-> tx_ptr[c] == $past(tx_base[c])); // R6
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rx_start[c] |-> $stable(rx_ptr[c])); // R4
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tx_start[c] |-> $stable(tx_ptr[c])); // R4
  end
endmodule

bind dma_init_seq dma_init_seq_chk #(.NCH(NCH), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .rx_start(rx_start), .tx_start(tx_start),
  .rx_base(rx_base), .tx_base(tx_base),
  .rx_ptr(rx_ptr), .tx_ptr(tx_ptr)
);

// File: tb/dma_init_seq_tb_top.sv
module dma_init_seq_tb_top;
  localparam int CLK_P = 10;
  localparam logic [8:0] VEC [7] = '{
    9'h100,  // R3 all via global bit
    9'h0FF,  // R10 every flag set
    9'h001,  // R4 ch0 rx only
    9'h080,  // R4 ch3 tx only
    9'h05A,  // R4 mixed
    9'h000,  // R4 nothing flagged
    9'h13C   // R3 global bit with partial flags
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] rx_start, tx_start;
  int total = 0, bad = 0;
  logic [31:0] m_rx [4], m_tx [4];

  always #(CLK_P/2) clk = ~clk;

  dma_init_seq dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                      .rdata(rdata), .rx_start(rx_start), .tx_start(tx_start));

  wire [7:0] st = {tx_start, rx_start};

  function automatic logic [5:0] ca(input int c, input int r);
    return {1'b1, 2'(c), 3'(r)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [7:0] pos(input int k);
    return 8'(1) << ((k % 2) ? 4 + k/2 : k/2);
  endfunction

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, d); chk("R1 global", d, 0);
    chk("R1 starts", {24'b0, st}, 0);
    for (int c = 0; c < 4; c++) begin
      rd(ca(c, 3), d); chk("R1 rx ptr", d, 0);
      rd(ca(c, 4), d); chk("R1 tx ptr", d, 0);
      m_rx[c] = 0; m_tx[c] = 0;
    end

    // R2 no start without action bit
    wr(ca(1, 1), 32'hABCD0001);
    wr(ca(1, 0), 32'h3);
    wr(6'h00, 32'h2);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); cnt += $countones(st);
    end
    chk("R2 no pulses", cnt, 0);
    rd(6'h00, d); chk("R2 action bit", d[0], 0);
    rd(ca(1, 0), d); chk("R2 flags kept", d, 3);
    rd(ca(1, 3), d); chk("R2 ptr kept", d, 0);

    // table: R3 R4 R5 R6 R7 R8 R10
    for (int v = 0; v < 7; v++) begin
      logic [7:0] msk, ex;
      msk = VEC[v][7:0];
      ex = VEC[v][8] ? 8'hFF : msk;
      for (int c = 0; c < 4; c++) begin
        wr(ca(c, 1), 32'h1000 + (v << 8) + (c << 4));
        wr(ca(c, 2), 32'h1001 + (v << 8) + (c << 4));
        wr(ca(c, 0), {30'b0, msk[2*c+1], msk[2*c]});
      end
      wr(6'h00, {30'b0, VEC[v][8], 1'b1});
      addr = 6'h00;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); #1;
        chk("R5 pulse slot", {24'b0, st}, ex[k] ? {24'b0, pos(k)} : 0);
        chk("R7 action bit", rdata[0], (k < 7) ? 1 : 0);
        if (ex[k]) begin
          if (k % 2) m_tx[k/2] = 32'h1001 + (v << 8) + ((k/2) << 4);
          else       m_rx[k/2] = 32'h1000 + (v << 8) + ((k/2) << 4);
        end
      end
      @(negedge clk);
      chk("R11 no trailing pulse", {24'b0, st}, 0);
      for (int c = 0; c < 4; c++) begin
        rd(ca(c, 3), d); chk("R6 R4 rx ptr", d, m_rx[c]);
        rd(ca(c, 4), d); chk("R6 R4 tx ptr", d, m_tx[c]);
        rd(ca(c, 0), d); chk("R8 flags clear", d, 0);
      end
    end

    // R9 pending request
    cnt = 0;
    wr(6'h00, 32'h3);
    addr = 6'h00;
    for (int i = 1; i <= 2; i++) begin
      @(negedge clk); cnt += $countones(st);
    end
    wr_en = 1'b1; wdata = 32'h3;
    @(negedge clk); cnt += $countones(st);
    wr_en = 1'b0;
    for (int i = 4; i <= 16; i++) begin
      @(negedge clk); #1; cnt += $countones(st);
      if (i == 8) chk("R9 still busy at E8", rdata[0], 1);
      if (i == 9) chk("R9 second scan no gap", {24'b0, st}, 32'h01);
    end
    chk("R9 pulse count", cnt, 16);
    chk("R9 action clears", rdata[0], 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule